// File: doc/BRIEF.md
# Twelve-Source Interrupt Request Controller

The controller collects interrupt requests from twelve sources: four external pins, four timers, an A/D converter, a watchdog, a basic interval timer and a serial port. Each source has an enable bit and a pending flag. A request pulse sets the pending flag, and the flag stays set until the interrupt is accepted. The CPU reaches both sets of bits through byte-wide registers at fixed addresses, and it can inspect, set or clear them with ordinary reads and writes.

A free-running divider defines sampling points. At each sampling point the controller looks at the pending flags. If no interrupt is already outstanding and the global enable input is high, it picks the highest-priority flag that is both pending and enabled. It then raises `irq_o` and drives the source's 4-bit index on `irq_vec_o`. A one-cycle acknowledge clears the accepted flag and drops `irq_o`. The next sampling point then arbitrates again among the remaining flags.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every enable bit and pending flag is 0, `irq_o` is low and every register reads 0.
- R2: Source index i is defined as follows: 0..3 are external pins 0..3, 4..7 are timers 0..3, 8 is the A/D converter, 9 the watchdog, 10 the basic interval timer and 11 the serial port. Enables for sources 0..7 live in register 0xF6, with source i at bit 7-i. Enables for sources 8..11 live in register 0xF4, with source i at bit 15-i.
- R3: Pending flags use the same bit layout, with sources 0..7 at 0xF7 and sources 8..11 at 0xF5. Both pending registers can be read and written. Bits 3..0 of 0xF4 and 0xF5 always read 0, and any other address reads 0x00.
- R4: A cycle with `src_req_i[i]` high sets pending flag i. The flag then holds until it is accepted or software writes it to 0.
- R5: A pending source whose enable bit is 0 is never signalled, and its flag stays set.
- R6: While `gie_i` is low no new interrupt is raised.
- R7: Among the flags that are pending and enabled, the lowest source index wins. `irq_vec_o` carries that index.
- R8: `irq_o` rises only in the cycle after a sampling point, and sampling points occur every SAMPLE_DIV cycles. While `irq_o` is high and unacknowledged, the vector is held.
- R9: `irq_ack_i` high while `irq_o` is high clears only the accepted source's flag, and `irq_o` is low on the next cycle. An acknowledge while `irq_o` is low has no effect.
- R10: In the same cycle, a hardware request overrides both a software write of 0 and an acknowledge clear of the same flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 12 | Request strobes, bit i = source i |
| gie_i | input | 1 | Global interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt outstanding |
| irq_vec_o | output | 4 | Index of the accepted source |
| irq_ack_i | input | 1 | One-cycle acknowledge |

## Verification
The hardest case to reach is a set of flags that are pending at one sampling point while the global enable is low. In that state the fixed priority decides the order of service across several acknowledges. The bench raises several requests with `gie_i` low, checks the pending registers, and only then raises `gie_i`. A queue holds the expected vectors, and a monitor acknowledges each interrupt, so the service order shows up directly. A single-cycle collision of a request with a clearing write is produced by driving both on the same clock edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 12;
  localparam int VEC_W   = 4;
  localparam int HI_SRC  = 8;

  localparam logic [7:0] ADDR_EN_LO   = 8'hF4;
  localparam logic [7:0] ADDR_PEND_LO = 8'hF5;
  localparam logic [7:0] ADDR_EN_HI   = 8'hF6;
  localparam logic [7:0] ADDR_PEND_HI = 8'hF7;

  // bit position of a source inside its register byte
  function automatic int src_bit(int src);
    return (src < HI_SRC) ? (HI_SRC - 1 - src) : (15 - src);
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int SAMPLE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam int CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o = (cnt_q == LAST);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] hw_set_i,
  input  logic [NUM_SRC-1:0] ack_clr_i,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] en_q, pend_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int          BP = src_bit(i);
    localparam logic [7:0]  EA = (i < HI_SRC) ? ADDR_EN_HI : ADDR_EN_LO;
    localparam logic [7:0]  PA = (i < HI_SRC) ? ADDR_PEND_HI : ADDR_PEND_LO;

    logic en_r, pd_r, pd_base;
    logic en_wr, pd_wr;

    assign en_wr = we_i && (addr_i == EA);
    assign pd_wr = we_i && (addr_i == PA);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_r <= 1'b0;
      else if (en_wr) en_r <= wdata_i[BP];
    end

    // write, then acknowledge clear, then hardware set wins
    always_comb begin
      pd_base = pd_wr ? wdata_i[BP] : pd_r;
      if (ack_clr_i[i]) pd_base = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pd_r <= 1'b0;
      else         pd_r <= pd_base | hw_set_i[i];
    end

    assign en_q[i]   = en_r;
    assign pend_q[i] = pd_r;
  end

  logic [7:0] en_hi, en_lo, pd_hi, pd_lo;

  always_comb begin
    en_hi = '0; en_lo = '0; pd_hi = '0; pd_lo = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (i < HI_SRC) begin
        en_hi[src_bit(i)] = en_q[i];
        pd_hi[src_bit(i)] = pend_q[i];
      end else begin
        en_lo[src_bit(i)] = en_q[i];
        pd_lo[src_bit(i)] = pend_q[i];
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_EN_HI:   rdata_o = en_hi;
      ADDR_EN_LO:   rdata_o = en_lo;
      ADDR_PEND_HI: rdata_o = pd_hi;
      ADDR_PEND_LO: rdata_o = pd_lo;
      default:      rdata_o = 8'h00;
    endcase
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  // R10
  hw_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set_i) |=> ((pend_q & $past(hw_set_i)) == $past(hw_set_i)));

  // R3
  lo_nibble_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_EN_LO || addr_i == ADDR_PEND_LO) |-> (rdata_o[3:0] == 4'h0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   idx_o
);
  // scan from lowest priority up so the lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VEC_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int SAMPLE_DIV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               gie_i,
  input  logic               reg_we_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic               irq_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  input  logic               irq_ack_i
);
  logic               smp_stb;
  logic [NUM_SRC-1:0] en, pend, live, ack_clr;
  logic               win_any;
  logic [VEC_W-1:0]   win_idx;
  logic               irq_q, ack_ok;
  logic [VEC_W-1:0]   vec_q;

  irq_sampler #(.SAMPLE_DIV(SAMPLE_DIV)) u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_o (smp_stb)
  );

  irq_regfile u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_set_i (src_req_i),
    .ack_clr_i(ack_clr),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .en_o     (en),
    .pend_o   (pend)
  );

  assign live = pend & en;

  irq_arbiter u_arb (
    .req_i(live),
    .any_o(win_any),
    .idx_o(win_idx)
  );

  assign ack_ok  = irq_ack_i && irq_q;
  assign ack_clr = ack_ok ? (NUM_SRC'(1) << vec_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else if (ack_ok) begin
      irq_q <= 1'b0;
    end else if (smp_stb && gie_i && win_any && !irq_q) begin
      irq_q <= 1'b1;
      vec_q <= win_idx;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  // R9
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_ack_i) |=> !irq_o);

  // R8
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> (irq_o && $stable(irq_vec_o)));

  // R8
  rise_on_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(smp_stb));

  // R6
  rise_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(gie_i));

  // R7
  no_higher_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (($past(live) & ((NUM_SRC'(1) << irq_vec_o) - NUM_SRC'(1))) == '0));

  // R5
  winner_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(live[win_idx]));
endmodule

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src_req = '0;
  logic        gie = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [3:0]  vec;
  logic        mon_ack = 1'b0;
  logic        drv_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  irq_ctrl #(.SAMPLE_DIV(DIV)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_req_i  (src_req),
    .gie_i      (gie),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq),
    .irq_vec_o  (vec),
    .irq_ack_i  (mon_ack | drv_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    chk(rdata == exp, req, rdata, exp);
    addr = '0;
  endtask

  task automatic pulse(input logic [11:0] m);
    @(negedge clk); src_req = m;
    @(negedge clk); src_req = '0;
  endtask

  task automatic set_gie(input logic v);
    @(negedge clk); gie = v;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while ((exp_q.size() != 0 || irq) && t < 200) begin
      @(negedge clk); t++;
    end
    chk(t < 200, req, exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet(input string req);
    bit seen = 0;
    repeat (3 * DIV) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  // monitor: pops expected vector on each raised interrupt and acknowledges it
  always @(negedge clk) begin
    if (rst_n && irq && !mon_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected irq", vec, 'hF);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(vec == 4'(e), "R7 vector", vec, e);
      end
      mon_ack <= 1'b1;
    end else begin
      mon_ack <= 1'b0;
    end
  end

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rd(8'hF4, 8'h00, "R1 en_lo");
    rd(8'hF5, 8'h00, "R1 pend_lo");
    rd(8'hF6, 8'h00, "R1 en_hi");
    rd(8'hF7, 8'h00, "R1 pend_hi");

    // R2 enable layout, R3 unused nibble
    wr(8'hF6, 8'hFF);
    wr(8'hF4, 8'hFF);
    rd(8'hF4, 8'hF0, "R3 en_lo nibble");
    rd(8'hF6, 8'hFF, "R2 en_hi");

    // R4 single request, timer1 = source 5
    set_gie(1'b1);
    exp_q.push_back(5);
    pulse(12'h020);
    drain("R4 single");
    rd(8'hF7, 8'h00, "R9 flag cleared");

    // R7 priority among simultaneous flags
    set_gie(1'b0);
    pulse(12'hA08);
    rd(8'hF7, 8'h10, "R3 pend_hi layout");
    rd(8'hF5, 8'h50, "R3 pend_lo layout");
    exp_q.push_back(3); exp_q.push_back(9); exp_q.push_back(11);
    set_gie(1'b1);
    drain("R7 order");
    rd(8'hF5, 8'h00, "R9 lo cleared");

    // R5 masking: only A/D enabled
    set_gie(1'b0);
    wr(8'hF6, 8'h00);
    wr(8'hF4, 8'h80);
    rd(8'hF4, 8'h80, "R2 en_lo A/D");
    pulse(12'h104);
    exp_q.push_back(8);
    set_gie(1'b1);
    drain("R5 masked");
    quiet("R5 no masked irq");
    rd(8'hF7, 8'h20, "R5 masked flag held");

    // R9 stray acknowledge
    set_gie(1'b0);
    @(negedge clk); drv_ack = 1'b1;
    @(negedge clk); drv_ack = 1'b0;
    rd(8'hF7, 8'h20, "R9 stray ack");

    // R6 global gate
    wr(8'hF6, 8'hFF);
    quiet("R6 gie low");
    rd(8'hF7, 8'h20, "R6 flag held");
    exp_q.push_back(2);
    set_gie(1'b1);
    drain("R6 release");

    // R3 software set of timer3 (source 7)
    exp_q.push_back(7);
    wr(8'hF7, 8'h01);
    drain("R3 sw set");

    // R3 software clear of serial (source 11)
    set_gie(1'b0);
    wr(8'hF4, 8'hF0);
    wr(8'hF5, 8'hFF);
    rd(8'hF5, 8'hF0, "R3 pend_lo nibble");
    wr(8'hF5, 8'h00);
    set_gie(1'b1);
    quiet("R3 sw clear");

    // R10 request against clearing write
    set_gie(1'b0);
    @(negedge clk); src_req = 12'h001; we = 1'b1; addr = 8'hF7; wdata = 8'h00;
    @(negedge clk); src_req = '0; we = 1'b0; addr = '0;
    rd(8'hF7, 8'h80, "R10 hw wins");
    exp_q.push_back(0);
    set_gie(1'b1);
    drain("R10 serviced");

    // R3 unmapped address
    wr(8'h10, 8'hFF);
    rd(8'h10, 8'h00, "R3 unmapped");

    report();
  end
endmodule